// File: doc/BRIEF.md
# Overlay Layer Pixel Unpacker

This block sits between the frame-buffer fetch of one overlay layer and the layer blender. It takes 32-bit words on a valid/ready stream and returns one RGB888 pixel with an 8-bit alpha on a second valid/ready stream. Each word passes through several stages in order:

- a byte-lane reorder chosen by a 2-bit mode;
- unpacking as one 24-bit pixel or as two 16-bit pixels;
- an optional exchange of the red and blue channels;
- selection of the alpha source;
- a comparison against a transparency key, which marks matching pixels.

Software writes the configuration into a shadow set: an 11-bit control word, a block alpha and a 24-bit key. The shadow set does nothing on its own. Software then raises an update request. The active set is loaded from the shadow set at the next frame-start pulse. The request flag stays visible until that load, so software can poll it to see when the update is done. An asynchronous active-low reset is asserted at once and released through a two-stage synchronizer.

Top module: `ovl_pix_unpack`

## Requirements
- R1: Reset state. During reset and once it is released, `out_valid` is 0, `upd_pending` is 0 and `in_ready` is 1. The active layer is disabled.
- R2: Byte-lane reorder. Input byte Bk is `in_data[8k+7:8k]`. Swizzle code `ctrl[9:8]` sets output lanes 0 to 3 as follows: code 0 gives B0,B1,B2,B3; code 1 gives B3,B2,B1,B0; code 2 gives B2,B3,B0,B1; code 3 gives B1,B0,B3,B2. All unpacking works on the reordered word.
- R3: 24-bit format. This is format code `ctrl[7:4]` = 4'b0011, and every code other than 4'b0101 behaves the same way. Each word gives one pixel: R = bits [23:16], G = [15:8], B = [7:0], and pixel alpha = [31:24].
- R4: 16-bit format, code 4'b0101. Each word gives two pixels, the low halfword first. A halfword has R in [15:11], G in [10:5] and B in [4:0]. Each channel is widened to 8 bits by copying its top bits into its low bits. Pixel alpha is 8'hFF.
- R5: When the red/blue exchange bit `ctrl[10]` is 1, the R and B channels swap places in the output.
- R6: Alpha source `ctrl[3:2]`:
  - 0 selects the pixel alpha.
  - 1 selects the block alpha.
  - 2 selects (pixel*block+127)/255, using integer division.
  - 3 behaves like 0.
- R7: When the key enable bit `ctrl[1]` is 1, `out_key_hit` is 1 exactly when the output RGB, after the red/blue exchange, equals the active key. The key holds R in [23:16], G in [15:8] and B in [7:0]. When `ctrl[1]` is 0, `out_key_hit` is 0.
- R8: While the layer enable bit `ctrl[0]` is 0, input words are accepted and discarded, and no pixel appears. A word dropped this way does not come out after the layer is enabled again.
- R9: Writes to the shadow set and frame-start pulses leave the active set unchanged until an update has been requested. `upd_pending` goes to 1 the cycle after `upd_req`. The next `frame_start` loads the active set and clears `upd_pending`.
- R10: While `out_valid` is 1 and `out_ready` is 0, the output pixel stays unchanged and no new input word is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse at each frame boundary |
| cfg_we | input | 1 | Write strobe for the shadow set |
| cfg_ctrl | input | 11 | Shadow control word: rb swap[10], swizzle[9:8], format[7:4], alpha sel[3:2], key en[1], layer en[0] |
| cfg_alpha | input | 8 | Shadow block alpha |
| cfg_key | input | 24 | Shadow transparency key {R,G,B} |
| upd_req | input | 1 | Requests a load of the shadow set at the next frame start |
| upd_pending | output | 1 | Update requested but not yet applied |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word accepted |
| in_data | input | 32 | Frame-buffer word |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Output pixel taken |
| out_rgb | output | 24 | Pixel {R,G,B} |
| out_alpha | output | 8 | Selected alpha |
| out_key_hit | output | 1 | Pixel matches the key (transparent) |

## Verification
The bench sends a word whose four bytes are all different through each swizzle code. A design with lane indices swapped would then return the wrong channel values. For the 16-bit format it checks both halves of a word and uses values whose top bits differ from their low bits. That exposes a design that emits the halves in the wrong order, or that widens channels with zeros instead of copying their top bits. The product alpha is checked at full scale (255*255) and at a value where rounding up and rounding down give different results. Keying is checked with the red/blue exchange on, which catches a comparison made before the exchange. The shadow set is checked across a frame start with no pending request, where it must stay unused. The output is also held under back-pressure while a second word waits, to catch a design that overwrites or drops the held pixel.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  localparam int unsigned CH_W   = 8;
  localparam int unsigned RGB_W  = 3 * CH_W;
  localparam int unsigned LANES  = 4;
  localparam int unsigned WORD_W = LANES * CH_W;
  localparam int unsigned HALF_W = WORD_W / 2;

  localparam logic [3:0] FMT_RGB888 = 4'b0011;
  localparam logic [3:0] FMT_RGB565 = 4'b0101;

  typedef enum logic [1:0] {
    ASEL_PIX = 2'd0,
    ASEL_BLK = 2'd1,
    ASEL_MUL = 2'd2,
    ASEL_RSV = 2'd3
  } asel_e;

  // Packed so that a cast of the 11-bit control word lines up field by field.
  typedef struct packed {
    logic       rb_swap;   // [10]
    logic [1:0] swz;       // [9:8]
    logic [3:0] fmt;       // [7:4]
    asel_e      asel;      // [3:2]
    logic       key_en;    // [1]
    logic       layer_en;  // [0]
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/ovl_rst_sync.sv
module ovl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/ovl_cfg_regs.sv
module ovl_cfg_regs
  import ovl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [CTRL_W-1:0]  cfg_ctrl,
  input  logic [CH_W-1:0]    cfg_alpha,
  input  logic [RGB_W-1:0]   cfg_key,
  input  logic               upd_req,
  input  logic               frame_start,
  output ctrl_t              act_ctrl,
  output logic [CH_W-1:0]    act_alpha,
  output logic [RGB_W-1:0]   act_key,
  output logic               pending
);
  ctrl_t             sh_ctrl_q, sh_ctrl_n, act_ctrl_q, act_ctrl_n;
  logic [CH_W-1:0]   sh_alpha_q, sh_alpha_n, act_alpha_q, act_alpha_n;
  logic [RGB_W-1:0]  sh_key_q, sh_key_n, act_key_q, act_key_n;
  logic              pend_q, pend_n;
  logic              load;

  always_comb begin
    sh_ctrl_n  = sh_ctrl_q;
    sh_alpha_n = sh_alpha_q;
    sh_key_n   = sh_key_q;
    if (cfg_we) begin
      sh_ctrl_n  = ctrl_t'(cfg_ctrl);
      sh_alpha_n = cfg_alpha;
      sh_key_n   = cfg_key;
    end
    load        = pend_q & frame_start;
    act_ctrl_n  = load ? sh_ctrl_q  : act_ctrl_q;
    act_alpha_n = load ? sh_alpha_q : act_alpha_q;
    act_key_n   = load ? sh_key_q   : act_key_q;
    pend_n      = upd_req | (pend_q & ~frame_start);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_ctrl_q   <= '0;
      sh_alpha_q  <= '0;
      sh_key_q    <= '0;
      act_ctrl_q  <= '0;
      act_alpha_q <= '0;
      act_key_q   <= '0;
      pend_q      <= 1'b0;
    end else begin
      sh_ctrl_q   <= sh_ctrl_n;
      sh_alpha_q  <= sh_alpha_n;
      sh_key_q    <= sh_key_n;
      act_ctrl_q  <= act_ctrl_n;
      act_alpha_q <= act_alpha_n;
      act_key_q   <= act_key_n;
      pend_q      <= pend_n;
    end
  end

  assign act_ctrl  = act_ctrl_q;
  assign act_alpha = act_alpha_q;
  assign act_key   = act_key_q;
  assign pending   = pend_q;
endmodule

// File: rtl/ovl_swizzle.sv
module ovl_swizzle #(
  parameter int unsigned LW = 8
) (
  input  logic [1:0]      mode,
  input  logic [4*LW-1:0] din,
  output logic [4*LW-1:0] dout
);
  // Every reorder is an XOR of the two lane-index bits.
  logic [1:0] xmask;

  always_comb begin
    case (mode)
      2'd1:    xmask = 2'b11;
      2'd2:    xmask = 2'b10;
      2'd3:    xmask = 2'b01;
      default: xmask = 2'b00;
    endcase
  end

  for (genvar i = 0; i < 4; i++) begin : g_lane
    logic [1:0] src;
    assign src = 2'(i) ^ xmask;
    assign dout[i*LW +: LW] = din[src*LW +: LW];
  end
endmodule

// File: rtl/ovl_pix_decode.sv
module ovl_pix_decode
  import ovl_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic              upper,
  input  ctrl_t             ctrl,
  input  logic [CH_W-1:0]   blk_alpha,
  input  logic [RGB_W-1:0]  key,
  output logic [RGB_W-1:0]  rgb,
  output logic [CH_W-1:0]   alpha,
  output logic              key_hit
);
  logic [HALF_W-1:0] hw;
  logic [CH_W-1:0]   r, g, b, pa, r_o, b_o;
  logic [2*CH_W-1:0] prod;
  logic [CH_W-1:0]   mul_a;

  always_comb begin
    hw = upper ? word[WORD_W-1:HALF_W] : word[HALF_W-1:0];
    if (ctrl.fmt == FMT_RGB565) begin
      r  = {hw[15:11], hw[15:13]};
      g  = {hw[10:5],  hw[10:9]};
      b  = {hw[4:0],   hw[4:2]};
      pa = '1;
    end else begin
      r  = word[3*CH_W-1:2*CH_W];
      g  = word[2*CH_W-1:CH_W];
      b  = word[CH_W-1:0];
      pa = word[WORD_W-1:3*CH_W];
    end
    r_o = ctrl.rb_swap ? b : r;
    b_o = ctrl.rb_swap ? r : b;
    rgb = {r_o, g, b_o};

    prod  = (2*CH_W)'(pa) * (2*CH_W)'(blk_alpha) + (2*CH_W)'(127);
    mul_a = CH_W'(prod / (2*CH_W)'(255));
    case (ctrl.asel)
      ASEL_BLK: alpha = blk_alpha;
      ASEL_MUL: alpha = mul_a;
      default:  alpha = pa;
    endcase

    key_hit = ctrl.key_en && (rgb == key);
  end
endmodule

// File: rtl/ovl_pix_unpack.sv
module ovl_pix_unpack
  import ovl_pkg::*;
#(
  parameter int unsigned RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              cfg_we,
  input  logic [10:0]       cfg_ctrl,
  input  logic [7:0]        cfg_alpha,
  input  logic [23:0]       cfg_key,
  input  logic              upd_req,
  output logic              upd_pending,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [31:0]       in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [23:0]       out_rgb,
  output logic [7:0]        out_alpha,
  output logic              out_key_hit
);
  logic              srst_n;
  ctrl_t             act_ctrl;
  logic [CH_W-1:0]   act_alpha;
  logic [RGB_W-1:0]  act_key;
  logic [WORD_W-1:0] word_q, swz_word;
  logic              vld_q, vld_n, half_q, half_n;
  logic              is565, last_pix, pop, accept, word_en;

  ovl_rst_sync #(.STAGES(RST_STAGES)) i_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  ovl_cfg_regs i_cfg_regs (
    .clk         (clk),
    .rst_n       (srst_n),
    .cfg_we      (cfg_we),
    .cfg_ctrl    (cfg_ctrl),
    .cfg_alpha   (cfg_alpha),
    .cfg_key     (cfg_key),
    .upd_req     (upd_req),
    .frame_start (frame_start),
    .act_ctrl    (act_ctrl),
    .act_alpha   (act_alpha),
    .act_key     (act_key),
    .pending     (upd_pending)
  );

  ovl_swizzle #(.LW(CH_W)) i_swizzle (
    .mode (act_ctrl.swz),
    .din  (word_q),
    .dout (swz_word)
  );

  ovl_pix_decode i_decode (
    .word      (swz_word),
    .upper     (half_q),
    .ctrl      (act_ctrl),
    .blk_alpha (act_alpha),
    .key       (act_key),
    .rgb       (out_rgb),
    .alpha     (out_alpha),
    .key_hit   (out_key_hit)
  );

  // Word holding stage and pixel sequencing
  always_comb begin
    is565     = (act_ctrl.fmt == FMT_RGB565);
    last_pix  = !is565 || half_q;
    out_valid = vld_q && act_ctrl.layer_en;
    pop       = out_valid && out_ready;
    in_ready  = !act_ctrl.layer_en || !vld_q || (pop && last_pix);
    accept    = in_valid && in_ready;
    word_en   = accept && act_ctrl.layer_en;

    vld_n  = vld_q;
    half_n = half_q;
    if (!act_ctrl.layer_en) begin
      vld_n  = 1'b0;
      half_n = 1'b0;
    end else begin
      if (pop) begin
        if (last_pix) begin
          vld_n  = 1'b0;
          half_n = 1'b0;
        end else begin
          half_n = 1'b1;
        end
      end
      if (word_en) begin
        vld_n  = 1'b1;
        half_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      vld_q  <= 1'b0;
      half_q <= 1'b0;
    end else begin
      vld_q  <= vld_n;
      half_q <= half_n;
    end
  end

  always_ff @(posedge clk) begin
    if (word_en) word_q <= in_data;
  end
endmodule

// File: rtl/ovl_pix_unpack_chk.sv
module ovl_pix_unpack_chk
  import ovl_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        frame_start,
  input logic        upd_req,
  input logic        upd_pending,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [23:0] out_rgb,
  input logic [7:0]  out_alpha,
  input logic        out_key_hit,
  input ctrl_t       act_ctrl
);
  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !frame_start) |=>
      (out_valid && $stable(out_rgb) && $stable(out_alpha) && $stable(out_key_hit)));

  // R9
  pending_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_req |=> upd_pending);

  // R9
  pending_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_pending && frame_start && !upd_req) |=> !upd_pending);

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd_pending && frame_start) |=> $stable(act_ctrl));

  // R8
  drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !act_ctrl.layer_en && !frame_start) |=> !out_valid);
endmodule

bind ovl_pix_unpack ovl_pix_unpack_chk i_chk (
  .clk         (clk),
  .rst_n       (srst_n),
  .frame_start (frame_start),
  .upd_req     (upd_req),
  .upd_pending (upd_pending),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_rgb     (out_rgb),
  .out_alpha   (out_alpha),
  .out_key_hit (out_key_hit),
  .act_ctrl    (act_ctrl)
);

// File: tb/test_ovl_pix_unpack.sv
module test_ovl_pix_unpack;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        frame_start, cfg_we, upd_req, upd_pending;
  logic [10:0] cfg_ctrl;
  logic [7:0]  cfg_alpha;
  logic [23:0] cfg_key;
  logic        in_valid, in_ready, out_valid, out_ready, out_key_hit;
  logic [31:0] in_data;
  logic [23:0] out_rgb;
  logic [7:0]  out_alpha;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  ovl_pix_unpack i_ovl_pix_unpack (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .cfg_we(cfg_we),
    .cfg_ctrl(cfg_ctrl), .cfg_alpha(cfg_alpha), .cfg_key(cfg_key),
    .upd_req(upd_req), .upd_pending(upd_pending),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_rgb(out_rgb),
    .out_alpha(out_alpha), .out_key_hit(out_key_hit)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // Expected reorder, written as the byte lists of R2
  function automatic logic [31:0] exp_swz(input logic [31:0] w, input logic [1:0] code);
    logic [7:0] b0, b1, b2, b3;
    b0 = w[7:0]; b1 = w[15:8]; b2 = w[23:16]; b3 = w[31:24];
    case (code)
      2'd0: return {b3, b2, b1, b0};
      2'd1: return {b0, b1, b2, b3};
      2'd2: return {b1, b0, b3, b2};
      default: return {b2, b3, b0, b1};
    endcase
  endfunction

  function automatic logic [23:0] exp565(input logic [15:0] h);
    logic [4:0] r5, b5;
    logic [5:0] g6;
    r5 = h[15:11]; g6 = h[10:5]; b5 = h[4:0];
    return {r5, r5[4:2], g6, g6[5:4], b5, b5[4:2]};
  endfunction

  function automatic logic [7:0] exp_mul(input int p, input int b);
    return 8'((p * b + 127) / 255);
  endfunction

  task automatic set_cfg(input logic [10:0] c, input logic [7:0] a, input logic [23:0] k);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ctrl = c; cfg_alpha = a; cfg_key = k;
    @(negedge clk);
    cfg_we = 1'b0; upd_req = 1'b1;
    @(negedge clk);
    upd_req = 1'b0; frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic push(input logic [31:0] w);
    @(negedge clk);
    in_valid = 1'b1; in_data = w;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pix(input logic [23:0] rgb, input logic [7:0] a, input logic k, input string req);
    chk({31'd0, out_valid}, 32'd1, {req, " out_valid"});
    chk({8'd0, out_rgb}, {8'd0, rgb}, {req, " rgb"});
    chk({24'd0, out_alpha}, {24'd0, a}, {req, " alpha"});
    chk({31'd0, out_key_hit}, {31'd0, k}, {req, " key_hit"});
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic t_reset;
    chk({31'd0, out_valid}, 32'd0, "R1 out_valid");
    chk({31'd0, upd_pending}, 32'd0, "R1 upd_pending");
    chk({31'd0, in_ready}, 32'd1, "R1 in_ready");
  endtask

  task automatic t_disabled;
    push(32'h80112233);
    chk({31'd0, out_valid}, 32'd0, "R8 no output while disabled");
    set_cfg(11'h031, 8'h00, 24'h0);
    chk({31'd0, out_valid}, 32'd0, "R8 dropped word stays dropped");
  endtask

  task automatic t_rgb888;
    push(32'h80112233);
    pix(24'h112233, 8'h80, 1'b0, "R3 word A");
    push(32'hFFA0B0C0);
    pix(24'hA0B0C0, 8'hFF, 1'b0, "R3 word B");
  endtask

  task automatic t_swizzle;
    for (int c = 1; c < 4; c++) begin
      logic [31:0] e;
      set_cfg(11'h031 | 11'(c << 8), 8'h00, 24'h0);
      e = exp_swz(32'h44332211, 2'(c));
      push(32'h44332211);
      pix(e[23:0], e[31:24], 1'b0, "R2 swizzle");
    end
  endtask

  task automatic t_rgb565;
    set_cfg(11'h051, 8'h00, 24'h0);
    push(32'hF80007E0);
    pix(exp565(16'h07E0), 8'hFF, 1'b0, "R4 low half first");
    pix(exp565(16'hF800), 8'hFF, 1'b0, "R4 high half");
    push(32'h001F8410);
    pix(exp565(16'h8410), 8'hFF, 1'b0, "R4 bit replicate");
    pix(exp565(16'h001F), 8'hFF, 1'b0, "R4 blue full");
  endtask

  task automatic t_rbswap;
    set_cfg(11'h431, 8'h00, 24'h0);
    push(32'h80112233);
    pix(24'h332211, 8'h80, 1'b0, "R5 red/blue swap");
  endtask

  task automatic t_alpha;
    set_cfg(11'h035, 8'h40, 24'h0);
    push(32'hC8010203);
    pix(24'h010203, 8'h40, 1'b0, "R6 block alpha");
    set_cfg(11'h039, 8'h64, 24'h0);
    push(32'hC8010203);
    pix(24'h010203, exp_mul(200, 100), 1'b0, "R6 product alpha");
    set_cfg(11'h039, 8'hFF, 24'h0);
    push(32'hFF010203);
    pix(24'h010203, exp_mul(255, 255), 1'b0, "R6 product full scale");
    set_cfg(11'h03D, 8'h10, 24'h0);
    push(32'h5A010203);
    pix(24'h010203, 8'h5A, 1'b0, "R6 code 3 as pixel alpha");
  endtask

  task automatic t_key;
    set_cfg(11'h033, 8'h00, 24'h112233);
    push(32'h80112233);
    pix(24'h112233, 8'h80, 1'b1, "R7 key match");
    push(32'h80112234);
    pix(24'h112234, 8'h80, 1'b0, "R7 key miss");
    set_cfg(11'h433, 8'h00, 24'h332211);
    push(32'h80112233);
    pix(24'h332211, 8'h80, 1'b1, "R7 key after swap");
    set_cfg(11'h031, 8'h00, 24'h112233);
    push(32'h80112233);
    pix(24'h112233, 8'h80, 1'b0, "R7 key disabled");
  endtask

  task automatic t_update;
    // active: 24-bit format; shadow gets 16-bit format without a request
    @(negedge clk);
    cfg_we = 1'b1; cfg_ctrl = 11'h051;
    @(negedge clk);
    cfg_we = 1'b0; frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    chk({31'd0, upd_pending}, 32'd0, "R9 no request no pending");
    push(32'h80112233);
    pix(24'h112233, 8'h80, 1'b0, "R9 shadow not applied");
    upd_req = 1'b1;
    @(negedge clk);
    upd_req = 1'b0;
    chk({31'd0, upd_pending}, 32'd1, "R9 pending set");
    push(32'h80112233);
    pix(24'h112233, 8'h80, 1'b0, "R9 old config until frame start");
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    chk({31'd0, upd_pending}, 32'd0, "R9 pending self-clears");
    push(32'hF80007E0);
    pix(exp565(16'h07E0), 8'hFF, 1'b0, "R9 new config applied");
    pix(exp565(16'hF800), 8'hFF, 1'b0, "R9 new config second half");
  endtask

  task automatic t_stall;
    set_cfg(11'h031, 8'h00, 24'h0);
    push(32'h80AABBCC);
    in_valid = 1'b1; in_data = 32'h40DDEEFF;
    chk({31'd0, in_ready}, 32'd0, "R10 in_ready low while held");
    repeat (3) @(negedge clk);
    chk({8'd0, out_rgb}, 32'h00AABBCC, "R10 pixel held");
    chk({31'd0, out_valid}, 32'd1, "R10 valid held");
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b0;
    pix(24'hDDEEFF, 8'h40, 1'b0, "R10 waiting word follows");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; frame_start = 1'b0; cfg_we = 1'b0; upd_req = 1'b0;
    cfg_ctrl = '0; cfg_alpha = '0; cfg_key = '0;
    in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_disabled;
    t_rgb888;
    t_swizzle;
    t_rgb565;
    t_rbswap;
    t_alpha;
    t_key;
    t_update;
    t_stall;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule